// File: doc/BRIEF.md
# Clock Failure Supervisor with Automatic Switchover

This block watches two oscillators: the one chosen as the system clock source and a slow watchdog oscillator that is expected to run at all times. Each oscillator is used to judge the other. When the system oscillator stops or runs far too slowly, the block forces the clock-select output to the watchdog encoding. An external glitch-free mux then moves the system clock onto the slow source. The block also pulses a non-maskable failure event. When the watchdog oscillator stalls, a separate event is raised and the clock selection is left unchanged.

Both oscillator inputs are brought into the supervisor's clock through two-flop synchronisers and an edge detector. The system-oscillator judge counts system edges over a window of watchdog periods. The watchdog judge counts system edges since the last watchdog edge. Software drives a single write port. That port loads the oscillator select, the two detector enables and the watchdog-oscillator enable, and it carries write-one-to-clear bits for the two sticky failure flags. Software should turn both detectors off around a change of oscillator select and may turn them on again once the write is done.

Top module: `cfm_clk_supervisor`

## Requirements
- R1: After reset the select output is 2'b00, both failure flags and both event outputs are 0, both detectors are disabled and the watchdog oscillator enable is 1.
- R2: A control write with no coincident failure loads the select value, and it appears on the select output on the clock after the write. Otherwise the select changes only on a forced recovery.
- R3: With system detection enabled, the watchdog oscillator enabled and a select other than 2'b11, a window of 8 watchdog periods that holds 0 or 1 system edges sets the sticky system flag. The same failure forces the select to 2'b11 (the watchdog encoding) and gives exactly one single-cycle system event pulse.
- R4: A system oscillator that gives two or more edges per window never raises a system failure.
- R5: No system failure and no switchover occur while the select is 2'b11 or while the watchdog oscillator enable is 0.
- R6: With the system detector disabled, a stopped system oscillator raises no flag and no event.
- R7: With watchdog detection enabled, 8004 system edges with no watchdog edge set the sticky watchdog flag and give exactly one watchdog event pulse. The select stays unchanged, and 8003 such edges raise nothing.
- R8: Every synchronised watchdog edge restarts the 8004-edge count.
- R9: Once a watchdog failure has been flagged, system-failure detection stays inhibited until reset, even after the watchdog flag is cleared.
- R10: Writing 1 to a clear bit clears only its own flag. Writing 0 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | supervisor clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sys_osc | input | 1 | system oscillator being supervised (asynchronous) |
| wdt_osc | input | 1 | watchdog oscillator (asynchronous) |
| wr_en | input | 1 | control write strobe |
| wr_sel | input | 2 | oscillator select value to load |
| wr_sys_det_en | input | 1 | system-oscillator detector enable |
| wr_wdt_det_en | input | 1 | watchdog-oscillator detector enable |
| wr_wdt_osc_en | input | 1 | watchdog oscillator enable |
| wr_clr_sys | input | 1 | write-one-to-clear of the system failure flag |
| wr_clr_wdt | input | 1 | write-one-to-clear of the watchdog failure flag |
| clk_sel | output | 2 | select to the external glitch-free clock mux |
| sys_fail_flag | output | 1 | sticky system-oscillator failure flag |
| wdt_fail_flag | output | 1 | sticky watchdog-oscillator failure flag |
| sys_fail_evt | output | 1 | one-cycle system failure event |
| wdt_fail_evt | output | 1 | one-cycle watchdog failure event |

## Verification
A table of cases drives the system oscillator in three ways while the watchdog runs: stopped, healthy, and very slow. The very slow case gives at most one edge per window. It separates the one-edge-means-too-slow threshold from a plain stopped check. The same table combines a stopped oscillator with the watchdog select, a disabled watchdog oscillator and a disabled detector, to show each gate suppresses recovery on its own. Directed runs with an exact count of system edges tell 8003 apart from 8004. A mid-count watchdog pulse shows that the count restarts. Further runs check the permanent inhibit after a watchdog failure and the per-flag clear bits.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    localparam int SEL_W = 2;
    typedef logic [SEL_W-1:0] osc_sel_t;
    localparam osc_sel_t SEL_RESET = 2'b00;
    localparam osc_sel_t SEL_WDT   = 2'b11;
endpackage

// File: rtl/cfm_sync_edge.sv
module cfm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-1:0], async_in};
        rise   = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cfm_sys_mon.sv
module cfm_sys_mon #(
    parameter int WIN_PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sys_rise,
    input  logic wdt_rise,
    output logic fail
);
    localparam int WC_W = $clog2(WIN_PERIODS + 1);

    typedef struct packed {
        logic            armed;
        logic [WC_W-1:0] wc;
        logic [1:0]      ec;
    } st_t;

    st_t s_d, s_q;
    logic [2:0] total;

    always_comb begin
        s_d   = s_q;
        fail  = 1'b0;
        total = {1'b0, s_q.ec} + {2'b00, sys_rise};
        if (!active) begin
            s_d = '0;
        end else begin
            if (sys_rise && s_q.ec != 2'd2) s_d.ec = s_q.ec + 2'd1;
            if (wdt_rise) begin
                if (!s_q.armed) begin
                    s_d.armed = 1'b1;
                    s_d.wc    = '0;
                    s_d.ec    = '0;
                end else if (s_q.wc == WC_W'(WIN_PERIODS - 1)) begin
                    fail   = (total <= 3'd1);
                    s_d.wc = '0;
                    s_d.ec = '0;
                end else begin
                    s_d.wc = s_q.wc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cfm_wdt_mon.sv
module cfm_wdt_mon #(
    parameter int LIMIT = 8004
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sys_rise,
    input  logic wdt_rise,
    output logic fail
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fail = 1'b0;
        if (!active || wdt_rise) begin
            s_d.cnt = '0;
        end else if (sys_rise) begin
            if (s_q.cnt == CW'(LIMIT - 1)) begin
                fail    = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cfm_clk_supervisor.sv
module cfm_clk_supervisor
    import cfm_pkg::*;
#(
    parameter int WIN_PERIODS = 8,
    parameter int WDT_LIMIT   = 8004,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sys_osc,
    input  logic           wdt_osc,
    input  logic           wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic           wr_sys_det_en,
    input  logic           wr_wdt_det_en,
    input  logic           wr_wdt_osc_en,
    input  logic           wr_clr_sys,
    input  logic           wr_clr_wdt,
    output logic [SEL_W-1:0] clk_sel,
    output logic           sys_fail_flag,
    output logic           wdt_fail_flag,
    output logic           sys_fail_evt,
    output logic           wdt_fail_evt
);
    typedef struct packed {
        osc_sel_t sel;
        logic     sys_det_en;
        logic     wdt_det_en;
        logic     wdt_osc_en;
        logic     sys_flag;
        logic     wdt_flag;
        logic     wdt_dead;
        logic     sys_evt;
        logic     wdt_evt;
    } st_t;

    localparam st_t RESET_ST = '{sel: SEL_RESET, wdt_osc_en: 1'b1, default: '0};

    st_t  s_d, s_q;
    logic sys_rise, wdt_rise;
    logic sys_active, wdt_active;
    logic sys_fail, wdt_fail;

    logic [1:0] osc_in, osc_rise;
    assign osc_in   = {wdt_osc, sys_osc};
    assign sys_rise = osc_rise[0];
    assign wdt_rise = osc_rise[1];

    for (genvar g = 0; g < 2; g++) begin : g_sync
        cfm_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (osc_in[g]),
            .rise     (osc_rise[g])
        );
    end

    cfm_sys_mon #(.WIN_PERIODS(WIN_PERIODS)) i_sys_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (sys_active),
        .sys_rise (sys_rise),
        .wdt_rise (wdt_rise),
        .fail     (sys_fail)
    );

    cfm_wdt_mon #(.LIMIT(WDT_LIMIT)) i_wdt_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (wdt_active),
        .sys_rise (sys_rise),
        .wdt_rise (wdt_rise),
        .fail     (wdt_fail)
    );

    always_comb begin
        sys_active = s_q.sys_det_en && s_q.wdt_osc_en && (s_q.sel != SEL_WDT)
                     && !s_q.wdt_dead && !s_q.sys_flag;
        wdt_active = s_q.wdt_det_en && s_q.wdt_osc_en && (s_q.sel != SEL_WDT)
                     && !s_q.wdt_dead;

        s_d         = s_q;
        s_d.sys_evt = 1'b0;
        s_d.wdt_evt = 1'b0;

        if (wr_en) begin
            s_d.sel        = wr_sel;
            s_d.sys_det_en = wr_sys_det_en;
            s_d.wdt_det_en = wr_wdt_det_en;
            s_d.wdt_osc_en = wr_wdt_osc_en;
            if (wr_clr_sys) s_d.sys_flag = 1'b0;
            if (wr_clr_wdt) s_d.wdt_flag = 1'b0;
        end

        if (sys_fail) begin
            s_d.sys_flag = 1'b1;
            s_d.sel      = SEL_WDT;
            s_d.sys_evt  = 1'b1;
        end

        if (wdt_fail) begin
            s_d.wdt_flag = 1'b1;
            s_d.wdt_dead = 1'b1;
            s_d.wdt_evt  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_ST;
        else        s_q <= s_d;
    end

    assign clk_sel       = s_q.sel;
    assign sys_fail_flag = s_q.sys_flag;
    assign wdt_fail_flag = s_q.wdt_flag;
    assign sys_fail_evt  = s_q.sys_evt;
    assign wdt_fail_evt  = s_q.wdt_evt;
endmodule

// File: rtl/cfm_supervisor_checker.sv
module cfm_supervisor_checker
    import cfm_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [SEL_W-1:0] clk_sel,
    input logic           sys_fail_flag,
    input logic           wdt_fail_flag,
    input logic           sys_fail_evt,
    input logic           wdt_fail_evt
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (clk_sel == SEL_RESET && !sys_fail_flag && !wdt_fail_flag
                    && !sys_fail_evt && !wdt_fail_evt));

    a_r2_sel_only_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$rose(sys_fail_flag)) |-> $stable(clk_sel));

    a_r3_forced_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_fail_flag) |-> (clk_sel == SEL_WDT));

    a_r3_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        sys_fail_evt |=> !sys_fail_evt);

    a_r3_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sys_fail_evt |-> sys_fail_flag);

    a_r5_no_fail_on_wdt_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_fail_flag) |-> ($past(clk_sel) != SEL_WDT));

    a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fail_evt |=> !wdt_fail_evt);

    a_r7_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wdt_fail_flag) && !$past(wr_en) && !$rose(sys_fail_flag)) |-> $stable(clk_sel));
endmodule

bind cfm_clk_supervisor cfm_supervisor_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .clk_sel       (clk_sel),
    .sys_fail_flag (sys_fail_flag),
    .wdt_fail_flag (wdt_fail_flag),
    .sys_fail_evt  (sys_fail_evt),
    .wdt_fail_evt  (wdt_fail_evt)
);

// File: tb/test_cfm_clk_supervisor.sv
`timescale 1ns/1ps
module test_cfm_clk_supervisor;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_sys_det_en = 0, wr_wdt_det_en = 0, wr_wdt_osc_en = 1;
    logic       wr_clr_sys = 0, wr_clr_wdt = 0;
    logic [1:0] wr_sel = 2'b00;
    logic [1:0] clk_sel;
    logic       sys_fail_flag, wdt_fail_flag, sys_fail_evt, wdt_fail_evt;

    // oscillator generators
    int   sys_half = 0;   // 0 = stopped
    int   wdt_half = 20;  // 0 = stopped
    logic gen_sys = 0, gen_wdt = 0, man_sys = 0, man_wdt = 0, manual = 0;
    int   sc = 0, wc = 0;
    logic sys_osc, wdt_osc;
    assign sys_osc = manual ? man_sys : gen_sys;
    assign wdt_osc = manual ? man_wdt : gen_wdt;

    always @(negedge clk) begin
        if (sys_half > 0) begin
            sc = sc + 1;
            if (sc >= sys_half) begin sc = 0; gen_sys = ~gen_sys; end
        end
        if (wdt_half > 0) begin
            wc = wc + 1;
            if (wc >= wdt_half) begin wc = 0; gen_wdt = ~gen_wdt; end
        end
    end

    int sys_evts = 0, wdt_evts = 0;
    always @(negedge clk) begin
        if (sys_fail_evt) sys_evts = sys_evts + 1;
        if (wdt_fail_evt) wdt_evts = wdt_evts + 1;
    end

    cfm_clk_supervisor i_cfm_clk_supervisor (
        .clk(clk), .rst_n(rst_n), .sys_osc(sys_osc), .wdt_osc(wdt_osc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_sys_det_en(wr_sys_det_en),
        .wr_wdt_det_en(wr_wdt_det_en), .wr_wdt_osc_en(wr_wdt_osc_en),
        .wr_clr_sys(wr_clr_sys), .wr_clr_wdt(wr_clr_wdt),
        .clk_sel(clk_sel), .sys_fail_flag(sys_fail_flag), .wdt_fail_flag(wdt_fail_flag),
        .sys_fail_evt(sys_fail_evt), .wdt_fail_evt(wdt_fail_evt)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (4) @(negedge clk);
        sys_evts = 0; wdt_evts = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic write(input logic [1:0] sel, input logic sde, input logic wde,
                         input logic oen, input logic cs, input logic cw);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_sys_det_en = sde; wr_wdt_det_en = wde;
        wr_wdt_osc_en = oen; wr_clr_sys = cs; wr_clr_wdt = cw;
        @(negedge clk);
        wr_en = 0; wr_clr_sys = 0; wr_clr_wdt = 0;
    endtask

    task automatic sys_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) man_sys = 1;
            @(negedge clk) man_sys = 0;
        end
    endtask

    // vector: [6:5] select, [4] sys detect en, [3] wdt osc en,
    //         [2:1] sys mode (0 stopped, 1 healthy, 2 very slow), [0] failure expected
    localparam int NV = 7;
    localparam logic [6:0] VEC [NV] = '{
        {2'b01, 1'b1, 1'b1, 2'd0, 1'b1},   // R3 stopped
        {2'b00, 1'b1, 1'b1, 2'd0, 1'b1},   // R3 stopped, other select
        {2'b10, 1'b1, 1'b1, 2'd1, 1'b0},   // R4 healthy
        {2'b01, 1'b1, 1'b1, 2'd2, 1'b1},   // R3 one edge per window
        {2'b11, 1'b1, 1'b1, 2'd0, 1'b0},   // R5 watchdog selected
        {2'b01, 1'b1, 1'b0, 2'd0, 1'b0},   // R5 watchdog osc off
        {2'b01, 1'b0, 1'b1, 2'd0, 1'b0}    // R6 detector off
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1", "sel", clk_sel, 0);
        check("R1", "sys flag", sys_fail_flag, 0);
        check("R1", "wdt flag", wdt_fail_flag, 0);
        check("R1", "events", sys_fail_evt | wdt_fail_evt, 0);

        // R2 write latency
        write(2'b10, 0, 0, 1, 0, 0);
        check("R2", "sel after write", clk_sel, 2);
        repeat (50) @(negedge clk);
        check("R2", "sel stable", clk_sel, 2);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            sys_half = 0; wdt_half = 20;
            do_reset();
            write(VEC[v][6:5], VEC[v][4], 0, VEC[v][3], 0, 0);
            case (VEC[v][2:1])
                2'd1: sys_half = 4;
                2'd2: sys_half = 400;
                default: sys_half = 0;
            endcase
            repeat (1500) @(negedge clk);
            check(VEC[v][0] ? "R3" : "R4/R5/R6", "sys flag", sys_fail_flag, VEC[v][0]);
            check(VEC[v][0] ? "R3" : "R4/R5/R6", "sel", clk_sel,
                  VEC[v][0] ? 3 : VEC[v][6:5]);
            check(VEC[v][0] ? "R3" : "R4/R5/R6", "sys events", sys_evts, VEC[v][0]);
        end

        // R10 clear bits: system flag is set after the last failing case; redo one
        sys_half = 0; wdt_half = 20;
        do_reset();
        write(2'b01, 1, 0, 1, 0, 0);
        repeat (1500) @(negedge clk);
        write(2'b11, 0, 0, 1, 0, 1);
        check("R10", "sys flag kept on clear 0", sys_fail_flag, 1);
        write(2'b11, 0, 0, 1, 1, 0);
        check("R10", "sys flag cleared", sys_fail_flag, 0);

        // R7 exact watchdog limit
        sys_half = 0; wdt_half = 0; manual = 1; man_sys = 0; man_wdt = 0;
        do_reset();
        write(2'b01, 0, 1, 1, 0, 0);
        sys_pulses(8003);
        repeat (6) @(negedge clk);
        check("R7", "no flag at 8003", wdt_fail_flag, 0);
        sys_pulses(1);
        repeat (6) @(negedge clk);
        check("R7", "flag at 8004", wdt_fail_flag, 1);
        check("R7", "one event", wdt_evts, 1);
        check("R7", "sel unchanged", clk_sel, 1);

        // R8 watchdog edge restarts the count
        do_reset();
        write(2'b01, 0, 1, 1, 0, 0);
        sys_pulses(8000);
        @(negedge clk) man_wdt = 1;
        repeat (4) @(negedge clk);
        man_wdt = 0;
        repeat (4) @(negedge clk);
        sys_pulses(8003);
        repeat (6) @(negedge clk);
        check("R8", "no flag after restart", wdt_fail_flag, 0);
        sys_pulses(1);
        repeat (6) @(negedge clk);
        check("R8", "flag after full count", wdt_fail_flag, 1);

        // R9 inhibit after watchdog failure, R10 clear of watchdog flag
        write(2'b01, 0, 0, 1, 0, 1);
        check("R10", "wdt flag cleared", wdt_fail_flag, 0);
        manual = 0; sys_half = 0; wdt_half = 20;
        write(2'b01, 1, 0, 1, 0, 0);
        repeat (1500) @(negedge clk);
        check("R9", "sys flag inhibited", sys_fail_flag, 0);
        check("R9", "sel unchanged", clk_sel, 1);
        check("R9", "no sys event", sys_evts, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule